// File: doc/BRIEF.md
# Cascaded Second-Level Interrupt Controller

This block gathers 32 interrupt sources into a single request line toward a parent interrupt controller. Each source is captured on a low-to-high transition of its input into a sticky pending bit. A per-source mask decides which pending bits may reach the parent line. Software reaches the block through a flat register port with a combinational read path and a write that takes effect at the next clock edge.

Both the pending word and the mask word are changed only through dedicated write-one-to-set and write-one-to-clear offsets. A handler acknowledges a source by writing that source's bit to the pending-clear offset, and raises a software interrupt through the pending-set offset. No read-modify-write sequence is needed for either. The pending word stays readable whatever the mask holds, so software can poll masked sources.

The combined output is produced by a two-state machine. `OUT_IDLE` moves to `OUT_RAISED` on the transition *any_pending* when at least one unmasked pending bit exists. `OUT_RAISED` returns to `OUT_IDLE` on the transition *none_pending* when no unmasked pending bit remains. In all other cases each state holds.

Top module: `l2irq_ctrl`

## Requirements
- R1: After reset every pending bit is 0, every mask bit is 1 (all sources masked) and `irq_o` is low.
- R2: A 0-to-1 transition on `src_i[n]` sets pending bit n, which stays set until cleared; a line held high does not set the bit again after it is cleared.
- R3: A write to byte offset 0x08 clears each pending bit whose data bit is 1; bits written as 0 are unchanged.
- R4: A write to byte offset 0x04 sets each pending bit whose data bit is 1; bits written as 0 are unchanged.
- R5: A write to offset 0x10 sets the mask bits written as 1, and a write to offset 0x14 clears the mask bits written as 1; bits written as 0 are unchanged in both cases. A read of offset 0x0C returns the mask, where 1 means masked.
- R6: A read of offset 0x00 returns the full pending word, including bits whose source is masked.
- R7: `irq_o` is high in a cycle exactly when the pending word AND NOT the mask was nonzero in the previous cycle. It is a registered output, so it lags a pending or mask change by one clock.
- R8: When a rising source edge and a pending-clear write hitting the same bit fall in the same cycle, the bit ends set.
- R9: Reads of any offset other than 0x00 and 0x0C return 0, and writes to offsets 0x00 and 0x0C change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Interrupt source lines, captured on rising transitions |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
The checker checks several rules on every cycle. A rising edge always leaves its bit set, even when a clear write hits that bit in the same cycle. Clear and mask writes take effect at the next edge. The pending word holds still when there is no write and no edge. The output always follows the previous cycle's unmasked pending set, and unmapped offsets read as zero. The rules that depend on history need the bench's scenarios to show them: the reset values, that a line held high is not captured again after an acknowledge, that masked bits stay visible at offset 0x00, and that writes to the two readable offsets have no effect. The bench compares the output and the read data against its behavioural model on every clock.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
    localparam int OFF_PEND     = 'h00;
    localparam int OFF_PEND_SET = 'h04;
    localparam int OFF_PEND_CLR = 'h08;
    localparam int OFF_MASK     = 'h0C;
    localparam int OFF_MASK_SET = 'h10;
    localparam int OFF_MASK_CLR = 'h14;

    typedef enum logic [2:0] {
        SEL_PEND,
        SEL_PEND_SET,
        SEL_PEND_CLR,
        SEL_MASK,
        SEL_MASK_SET,
        SEL_MASK_CLR,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic {
        OUT_IDLE,
        OUT_RAISED
    } out_state_e;
endpackage

// File: rtl/l2irq_regif.sv
module l2irq_regif
    import l2irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    input  logic [NUM_SRC-1:0] pend_q,
    input  logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] pend_set,
    output logic [NUM_SRC-1:0] pend_clr,
    output logic [NUM_SRC-1:0] mask_set,
    output logic [NUM_SRC-1:0] mask_clr,
    output logic [NUM_SRC-1:0] bus_rdata
);
    reg_sel_e sel;

    always_comb begin
        if      (bus_addr == ADDR_W'(OFF_PEND))     sel = SEL_PEND;
        else if (bus_addr == ADDR_W'(OFF_PEND_SET)) sel = SEL_PEND_SET;
        else if (bus_addr == ADDR_W'(OFF_PEND_CLR)) sel = SEL_PEND_CLR;
        else if (bus_addr == ADDR_W'(OFF_MASK))     sel = SEL_MASK;
        else if (bus_addr == ADDR_W'(OFF_MASK_SET)) sel = SEL_MASK_SET;
        else if (bus_addr == ADDR_W'(OFF_MASK_CLR)) sel = SEL_MASK_CLR;
        else                                        sel = SEL_NONE;
    end

    always_comb begin
        pend_set = '0;
        pend_clr = '0;
        mask_set = '0;
        mask_clr = '0;
        if (bus_wr) begin
            unique case (sel)
                SEL_PEND_SET: pend_set = bus_wdata;
                SEL_PEND_CLR: pend_clr = bus_wdata;
                SEL_MASK_SET: mask_set = bus_wdata;
                SEL_MASK_CLR: mask_clr = bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_PEND: bus_rdata = pend_q;
            SEL_MASK: bus_rdata = mask_q;
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/l2irq_pending.sv
module l2irq_pending #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] set_bits,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] pend_q
);
    logic [NUM_SRC-1:0] src_d;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
        logic edge_seen;
        assign edge_seen = src_i[n] & ~src_d[n];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                src_d[n]  <= 1'b0;
                pend_q[n] <= 1'b0;
            end else begin
                src_d[n]  <= src_i[n];
                // a fresh edge overrides a same-cycle clear
                pend_q[n] <= edge_seen | ((pend_q[n] | set_bits[n]) & ~clr_bits[n]);
            end
        end
    end
endmodule

// File: rtl/l2irq_mask.sv
module l2irq_mask #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] set_bits,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] mask_q
);
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) mask_q[n] <= 1'b1;
            else        mask_q[n] <= (mask_q[n] | set_bits[n]) & ~clr_bits[n];
        end
    end
endmodule

// File: rtl/l2irq_out_fsm.sv
module l2irq_out_fsm
    import l2irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pending,
    output logic irq_o
);
    out_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OUT_IDLE:   if (any_pending)  state_d = OUT_RAISED;
            OUT_RAISED: if (!any_pending) state_d = OUT_IDLE;
            default:    state_d = OUT_IDLE;
        endcase
    end

    assign irq_o = (state_q == OUT_RAISED);
endmodule

// File: rtl/l2irq_ctrl.sv
module l2irq_ctrl #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] pend_q, mask_q;
    logic [NUM_SRC-1:0] pend_set, pend_clr, mask_set, mask_clr;

    l2irq_regif #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regif (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .pend_q   (pend_q),
        .mask_q   (mask_q),
        .pend_set (pend_set),
        .pend_clr (pend_clr),
        .mask_set (mask_set),
        .mask_clr (mask_clr),
        .bus_rdata(bus_rdata)
    );

    l2irq_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_i),
        .set_bits(pend_set),
        .clr_bits(pend_clr),
        .pend_q  (pend_q)
    );

    l2irq_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_bits(mask_set),
        .clr_bits(mask_clr),
        .mask_q  (mask_q)
    );

    l2irq_out_fsm u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_pending(|(pend_q & ~mask_q)),
        .irq_o      (irq_o)
    );
endmodule

// File: rtl/l2irq_ctrl_chk.sv
module l2irq_ctrl_chk #(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_wr,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic [NUM_SRC-1:0] bus_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] pend_q,
    input logic [NUM_SRC-1:0] mask_q
);
    logic [NUM_SRC-1:0] src_prev;
    logic [NUM_SRC-1:0] rise;
    logic wr_pclr, wr_mset, wr_mclr;

    always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src_i;
    end

    assign rise    = src_i & ~src_prev;
    assign wr_pclr = bus_wr && (bus_addr == ADDR_W'('h08));
    assign wr_mset = bus_wr && (bus_addr == ADDR_W'('h10));
    assign wr_mclr = bus_wr && (bus_addr == ADDR_W'('h14));

    // R2 and R8: an edge always lands, a clear in the same cycle notwithstanding
    p_edge_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pclr |=> ((pend_q & $past(bus_wdata & ~rise)) == '0));

    p_pend_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && rise == '0) |=> $stable(pend_q));

    p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mset |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata)));

    p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mclr |=> ((mask_q & $past(bus_wdata)) == '0));

    p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pend_q & ~mask_q))));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != ADDR_W'('h00) && bus_addr != ADDR_W'('h0C)) |-> (bus_rdata == '0));
endmodule

bind l2irq_ctrl l2irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_o    (irq_o),
    .pend_q   (pend_q),
    .mask_q   (mask_q)
);

// File: tb/l2irq_ctrl_tb.sv
`timescale 1ns/1ps
module l2irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [31:0] m_pend, m_mask, m_src_prev;
    logic        m_irq;

    always #2 clk = ~clk;   // 250 MHz

    l2irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_mask = '1; m_src_prev = '0; m_irq = 1'b0;
        end else begin
            logic [31:0] p, k;
            m_irq = (m_pend & ~m_mask) != 0;
            p = m_pend; k = m_mask;
            if (bus_wr) begin
                if (bus_addr == 8'h04) p = p | bus_wdata;
                if (bus_addr == 8'h08) p = p & ~bus_wdata;
                if (bus_addr == 8'h10) k = k | bus_wdata;
                if (bus_addr == 8'h14) k = k & ~bus_wdata;
            end
            p = p | (src_i & ~m_src_prev);
            m_pend = p; m_mask = k; m_src_prev = src_i;
        end
    end

    function automatic logic [31:0] model_rd(input logic [7:0] a);
        if (a == 8'h00) return m_pend;
        if (a == 8'h0C) return m_mask;
        return 32'h0;
    endfunction

    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (irq_o !== m_irq || bus_rdata !== model_rd(bus_addr)) begin
                fails++;
                $display("FAIL %s addr=%h: irq=%b rdata=%h, expected irq=%b rdata=%h",
                         cur_req, bus_addr, irq_o, bus_rdata, m_irq, model_rd(bus_addr));
            end
        end
    end

    task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d,
                       input logic [31:0] s);
        @(posedge clk); #1;
        bus_addr = a; bus_wr = w; bus_wdata = d; src_i = s;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] s);
        cyc(a, 1'b0, '0, s);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values
        cur_req = "R1";
        rd(8'h0C, '0); rd(8'h00, '0); rd(8'h00, '0);
        // R5: unmask bits 0, 5, 31; zero bits keep their mask
        cur_req = "R5";
        cyc(8'h14, 1'b1, 32'h8000_0021, '0);
        rd(8'h0C, '0); rd(8'h0C, '0);
        // R2/R7: edge on source 5 latches and raises irq a cycle later
        cur_req = "R2";
        rd(8'h00, 32'h20); rd(8'h00, 32'h20); rd(8'h00, 32'h20);
        // R2: acknowledge while line still high, no relatch
        cyc(8'h08, 1'b1, 32'h20, 32'h20);
        rd(8'h00, 32'h20); rd(8'h00, 32'h20); rd(8'h00, '0); rd(8'h00, '0);
        // R6: masked source 10 visible, irq stays low
        cur_req = "R6";
        rd(8'h00, 32'h400); rd(8'h00, 32'h400); rd(8'h00, '0);
        cyc(8'h08, 1'b1, 32'h400, '0); rd(8'h00, '0);
        // R4: software raise of bit 31
        cur_req = "R4";
        cyc(8'h04, 1'b1, 32'h8000_0000, '0);
        rd(8'h00, '0); rd(8'h00, '0);
        // R3: partial clear leaves other bits
        cur_req = "R3";
        cyc(8'h04, 1'b1, 32'h0000_00FF, '0);
        cyc(8'h08, 1'b1, 32'h8000_000F, '0);
        rd(8'h00, '0); rd(8'h00, '0);
        cyc(8'h08, 1'b1, 32'hFFFF_FFFF, '0);
        rd(8'h00, '0); rd(8'h00, '0);
        // R8: edge and clear on bit 1 in the same cycle
        cur_req = "R8";
        cyc(8'h04, 1'b1, 32'h2, '0);
        cyc(8'h08, 1'b1, 32'h2, 32'h2);
        rd(8'h00, 32'h2); rd(8'h00, '0);
        // R9: writes to readable offsets ignored, other offsets read zero
        cur_req = "R9";
        cyc(8'h00, 1'b1, 32'h0, '0);
        cyc(8'h0C, 1'b1, 32'h0, '0);
        rd(8'h00, '0); rd(8'h0C, '0);
        rd(8'h04, '0); rd(8'h08, '0); rd(8'h10, '0); rd(8'h14, '0);
        rd(8'h18, '0); rd(8'hFC, '0); rd(8'h01, '0);
        // R5/R7: unmask bit 1 then mask everything, irq follows
        cur_req = "R7";
        cyc(8'h14, 1'b1, 32'h2, '0);
        rd(8'h0C, '0); rd(8'h0C, '0);
        cyc(8'h10, 1'b1, 32'hFFFF_FFFF, '0);
        rd(8'h0C, '0); rd(8'h00, '0); rd(8'h00, '0);
        @(posedge clk); @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule